// File: doc/BRIEF.md
# Baud Divisor Validator with Running Average

This block sits behind an automatic baud-rate measurement unit and screens every 16-bit divisor that unit reports. Each candidate arrives with a one-cycle strobe and is compared with an acceptance window. The window is centred on a configured nominal divisor and extends a configured tolerance above and below it. A candidate inside the window is forwarded unchanged and also feeds a running average.

A candidate outside the window is discarded. In its place the block forwards the current running average and raises a flag. The average comes from a leaky integrator with an effective depth of 16 samples. After reset it equals the nominal divisor, so a string of bad measurements falls back to a known-good rate instead of locking the receiver onto a wrong one.

A typical setup uses a nominal divisor of 0x0067 and a tolerance of 0x05. That gives an acceptance window of 0x0062 to 0x006C.

Top module: `baud_div_validator`

## Requirements
- R1: While `rst` is high at a clock edge, the average output is loaded with `cfg_nominal`, the internal integrator is loaded with 15 times `cfg_nominal`, and `res_valid` is cleared.
- R2: The lower limit is `cfg_nominal - cfg_tol`, held at 0 if that would go negative. The upper limit is `cfg_nominal + cfg_tol`, held at 0xFFFF if that would overflow. Both comparisons are unsigned and inclusive.
- R3: When a candidate lies within the limits, the next cycle shows `res_div` equal to the candidate and `res_reject` = 0.
- R4: When a candidate lies outside the limits, the next cycle shows `res_div` equal to the average held before that candidate, and `res_reject` = 1.
- R5: An accepted candidate v updates the average in the same cycle. With s = integrator + v, the new average is floor(s / 16) and the new integrator is s minus the new average.
- R6: A rejected candidate leaves both the integrator and the average unchanged.
- R7: `res_valid` pulses high for exactly the cycle after each `meas_valid` cycle and is low otherwise. Cycles without `meas_valid` change neither the average nor the integrator.
- R8: `res_div` and `res_reject` hold their last values between strobes.
- R9: The integrator never exceeds 15 × 0xFFFF, so its 20 bits cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nominal | input | 16 | Nominal divisor (window centre and average start value) |
| cfg_tol | input | 16 | Allowed deviation either side of the nominal divisor |
| meas_div | input | 16 | Candidate divisor from the measurement unit |
| meas_valid | input | 1 | One-cycle strobe qualifying `meas_div` |
| res_div | output | 16 | Divisor to use (candidate or running average) |
| res_reject | output | 1 | High when the last candidate fell outside the window |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| avg_div | output | 16 | Current running average |

## Verification
The in-RTL properties check the following on every cycle:
- the one-cycle latency of the result strobe;
- that an accepted result equals the candidate and a rejected one equals the previous average;
- that a rejection leaves the average frozen;
- the integrator's upper bound.

Only the bench scenarios can show the exact numerical path of the average over a sequence, the inclusive limit edges, and the saturation of the limits near zero and near full scale. Three configurations are swept exhaustively through and beyond their windows for this purpose, with a reference model kept in plain integers.

// File: rtl/bdv_pkg.sv
package bdv_pkg;
  typedef enum logic {
    VERDICT_PASS = 1'b0,
    VERDICT_FAIL = 1'b1
  } verdict_e;
endpackage

// File: rtl/bdv_window.sv
module bdv_window #(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] center,
  input  logic [DIV_W-1:0] spread,
  input  logic [DIV_W-1:0] sample,
  output bdv_pkg::verdict_e verdict
);
  localparam int EXT_W = DIV_W + 1;

  logic [EXT_W-1:0] hi_sum;
  logic [DIV_W-1:0] lo_lim;
  logic [DIV_W-1:0] hi_lim;

  always_comb begin
    hi_sum = {1'b0, center} + {1'b0, spread};
    hi_lim = hi_sum[DIV_W] ? {DIV_W{1'b1}} : hi_sum[DIV_W-1:0];
    lo_lim = (center < spread) ? '0 : (center - spread);
    if ((sample >= lo_lim) && (sample <= hi_lim))
      verdict = bdv_pkg::VERDICT_PASS;
    else
      verdict = bdv_pkg::VERDICT_FAIL;
  end
endmodule

// File: rtl/bdv_leaky_avg.sv
module bdv_leaky_avg #(
  parameter int DIV_W   = 16,
  parameter int SHIFT_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] seed,
  input  logic             upd_en,
  input  logic [DIV_W-1:0] sample,
  output logic [DIV_W-1:0] avg_o
);
  localparam int ACC_W = DIV_W + SHIFT_N;
  localparam logic [ACC_W-1:0] MAX_DIV = ACC_W'((1 << DIV_W) - 1);
  localparam logic [ACC_W-1:0] ACC_CAP = (MAX_DIV << SHIFT_N) - MAX_DIV;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] seed_ext;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] avg_next;

  always_comb begin
    seed_ext = {{SHIFT_N{1'b0}}, seed};
    sum      = acc_q + {{SHIFT_N{1'b0}}, sample};
    avg_next = sum >> SHIFT_N;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= (seed_ext << SHIFT_N) - seed_ext;
      avg_o <= seed;
    end else if (upd_en) begin
      acc_q <= sum - avg_next;
      avg_o <= avg_next[DIV_W-1:0];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_CAP);

  // R6
  avg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(avg_o));
endmodule

// File: rtl/baud_div_validator.sv
module baud_div_validator #(
  parameter int DIV_W   = 16,
  parameter int SHIFT_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_nominal,
  input  logic [DIV_W-1:0] cfg_tol,
  input  logic [DIV_W-1:0] meas_div,
  input  logic             meas_valid,
  output logic [DIV_W-1:0] res_div,
  output logic             res_reject,
  output logic             res_valid,
  output logic [DIV_W-1:0] avg_div
);
  import bdv_pkg::*;

  verdict_e verdict;
  logic     take;

  bdv_window #(.DIV_W(DIV_W)) u_window (
    .center (cfg_nominal),
    .spread (cfg_tol),
    .sample (meas_div),
    .verdict(verdict)
  );

  assign take = meas_valid && (verdict == VERDICT_PASS);

  bdv_leaky_avg #(.DIV_W(DIV_W), .SHIFT_N(SHIFT_N)) u_avg (
    .clk   (clk),
    .rst   (rst),
    .seed  (cfg_nominal),
    .upd_en(take),
    .sample(meas_div),
    .avg_o (avg_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_reject <= 1'b0;
      res_div    <= cfg_nominal;
    end else begin
      res_valid <= meas_valid;
      if (meas_valid) begin
        res_reject <= (verdict == VERDICT_FAIL);
        res_div    <= (verdict == VERDICT_PASS) ? meas_div : avg_div;
      end
    end
  end

  // R7
  strobe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> res_valid);
  // R7
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> !res_valid);
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_reject) |-> (res_div == $past(meas_div)));
  // R4
  substitute_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_reject) |-> (res_div == $past(avg_div)));
  // R6
  reject_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_reject) |-> $stable(avg_div));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> ($stable(res_div) && $stable(res_reject)));
endmodule

// File: tb/baud_div_validator_bench.sv
module baud_div_validator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_nominal = 16'h0067;
  logic [15:0] cfg_tol = 16'h0005;
  logic [15:0] meas_div = '0;
  logic        meas_valid = 1'b0;
  logic [15:0] res_div;
  logic        res_reject;
  logic        res_valid;
  logic [15:0] avg_div;

  int total = 0;
  int bad = 0;
  int m_acc;
  int m_avg;
  int m_lo;
  int m_hi;

  always #5 clk = ~clk;

  baud_div_validator u_baud_div_validator (
    .clk(clk), .rst(rst), .cfg_nominal(cfg_nominal), .cfg_tol(cfg_tol),
    .meas_div(meas_div), .meas_valid(meas_valid), .res_div(res_div),
    .res_reject(res_reject), .res_valid(res_valid), .avg_div(avg_div)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int nom, input int tol);
    @(negedge clk);
    cfg_nominal = 16'(nom);
    cfg_tol = 16'(tol);
    meas_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_avg = nom;
    m_acc = 15 * nom;
    m_lo = (nom < tol) ? 0 : nom - tol;
    m_hi = (nom + tol > 65535) ? 65535 : nom + tol;
    chk("R1 avg", avg_div, nom);
    chk("R1 valid", res_valid, 0);
  endtask

  task automatic send(input int v);
    int  exp_div;
    int  exp_rej;
    int  s;
    logic [15:0] hold_div;
    logic hold_rej;
    meas_div = 16'(v);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    if (v >= m_lo && v <= m_hi) begin
      exp_div = v;
      exp_rej = 0;
      s = m_acc + v;
      m_avg = s / 16;
      m_acc = s - m_avg;
    end else begin
      exp_div = m_avg;
      exp_rej = 1;
    end
    chk("R7 pulse", res_valid, 1);
    chk(exp_rej ? "R4 div" : "R3 div", res_div, exp_div);
    chk("R2 verdict", res_reject, exp_rej);
    chk(exp_rej ? "R6 avg" : "R5 avg", avg_div, m_avg);
    hold_div = res_div;
    hold_rej = res_reject;
    meas_div = 16'(v ^ 16'h00A5);
    @(negedge clk);
    chk("R7 idle", res_valid, 0);
    chk("R8 div", res_div, hold_div);
    chk("R8 rej", res_reject, hold_rej);
    chk("R7 avg idle", avg_div, m_avg);
  endtask

  initial begin
    do_reset(16'h0067, 16'h0005);
    for (int v = 16'h005A; v <= 16'h0074; v++) send(v);
    for (int v = 16'h0074; v >= 16'h005A; v--) send(v);
    send(16'h0000);
    send(16'hFFFF);
    do_reset(2, 5);
    for (int v = 0; v <= 10; v++) send(v);
    send(16'hFFFF);
    do_reset(16'hFFFD, 5);
    for (int v = 16'hFFF0; v <= 16'hFFFF; v++) send(v);
    send(0);
    do_reset(16'h0067, 16'h0005);
    for (int k = 0; k < 40; k++) send(16'h006C);
    for (int k = 0; k < 40; k++) send(16'h0062);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule